// File: doc/BRIEF.md
# Flash Protected-Range Guard

This block sits in front of a serial flash engine and decides whether each flash access may go ahead. It keeps six protected-range registers. Each names a first and a last 4 KiB granule, plus two independent enables: one that blocks reads and one that blocks writes and erases. A requester presents a byte address and an access kind on a strobe. One clock later the block answers with a deny flag, which is raised when any enabled range of the matching kind covers the address.

Software programs the ranges over a simple 32-bit register port. A sticky lock bit freezes the whole register set, so that once boot code has fixed the protection map, nothing can loosen it before the next reset. Ranges whose first granule lies above their last granule, or that have neither enable set, never block anything.

Top module: `flash_prot_guard`

## Requirements
- R1: Range register k (k = 0..5) sits at byte offset 4*k. Its fields are: base granule in bits 13:0, inclusive limit granule in bits 29:16, read-protect enable in bit 15, and write-protect enable in bit 31. Bits 14 and 30 read back as zero whatever was written.
- R2: After reset every range register reads zero, the lock reads zero and rsp_valid is low.
- R3: A range covers the byte addresses from base*4096 through limit*4096+4095, both ends included.
- R4: A read (req_write=0) is denied exactly when some range with read-protect set covers the address. A write-protect enable alone never denies a read.
- R5: A write or erase (req_write=1) is denied exactly when some range with write-protect set covers the address. A read-protect enable alone never denies a write.
- R6: A range with neither enable set never denies any access.
- R7: A range whose base is greater than its limit covers no address.
- R8: Writing a 1 in bit 0 of offset 0x18 sets the lock, which reads back in bit 0 of that offset. Once the lock is set, writes to the range registers and to the lock itself are ignored until reset.
- R9: rsp_valid is high in the cycle after each cycle with req_valid high, and low otherwise. rsp_deny is low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset (word aligned) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| req_valid | input | 1 | Access check request strobe |
| req_addr | input | ADDR_W (24) | Flash byte address to check |
| req_write | input | 1 | 1 = write or erase, 0 = read |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_deny | output | 1 | 1 = access blocked by a protected range |

## Verification
The assertions assume that register writes use word-aligned offsets and that req_addr carries no X while req_valid is high. Under those assumptions each per-range hit line can be related to the stored enables and ordering of that range. The bench keeps bus_addr aligned and drives every request input only on falling edges. It programs a map that mixes read-only, write-only, both-enabled, unenabled and inverted ranges. It then sweeps every granule of the low address space at its first, middle and last byte, for both access kinds.

// File: rtl/prg_pkg.sv
package prg_pkg;

  localparam int FIELD_W    = 14;
  localparam int GRAN_SHIFT = 12;

  // One protection window, stored without the unused bit positions.
  typedef struct packed {
    logic               wp;
    logic               rp;
    logic [FIELD_W-1:0] limit;
    logic [FIELD_W-1:0] base;
  } prange_t;

  function automatic prange_t word_to_range(input logic [31:0] w);
    prange_t r;
    r.base  = w[FIELD_W-1:0];
    r.rp    = w[15];
    r.limit = w[16 +: FIELD_W];
    r.wp    = w[31];
    return r;
  endfunction

  function automatic logic [31:0] range_to_word(input prange_t r);
    logic [31:0] w;
    w = '0;
    w[FIELD_W-1:0]   = r.base;
    w[15]            = r.rp;
    w[16 +: FIELD_W] = r.limit;
    w[31]            = r.wp;
    return w;
  endfunction

  // Granule-level inclusive window test; an inverted window covers nothing.
  function automatic logic range_covers(input prange_t r, input logic [31:0] addr);
    logic [31:0] gran;
    logic [31:0] lo;
    logic [31:0] hi;
    gran = addr >> GRAN_SHIFT;
    lo   = 32'(r.base);
    hi   = 32'(r.limit);
    return (lo <= hi) && (gran >= lo) && (gran <= hi);
  endfunction

endpackage

// File: rtl/prg_reg_bank.sv
module prg_reg_bank
  import prg_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int OFF_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [OFF_W-1:0]           bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output prange_t [NUM_RANGES-1:0]   ranges,
  output logic                       locked
);

  localparam int WIDX_W   = OFF_W - 2;
  localparam int LOCK_IDX = NUM_RANGES;

  prange_t [NUM_RANGES-1:0] ranges_q;
  logic                     lock_q;
  logic [WIDX_W-1:0]        widx;
  logic                     aligned;
  logic                     wr_ok;
  logic                     lock_set;

  assign widx     = bus_addr[OFF_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_ok    = bus_we && aligned && !lock_q;
  assign lock_set = wr_ok && (32'(widx) == LOCK_IDX) && bus_wdata[0];

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
    logic sel_wr;
    assign sel_wr = wr_ok && (32'(widx) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ranges_q[i] <= '0;
      else if (sel_wr) ranges_q[i] <= word_to_range(bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NUM_RANGES; i++)
        if (32'(widx) == i) bus_rdata = range_to_word(ranges_q[i]);
      if (32'(widx) == LOCK_IDX) bus_rdata = {31'b0, lock_q};
    end
  end

  assign ranges = ranges_q;
  assign locked = lock_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ranges_q)); // R8

endmodule

// File: rtl/prg_range_match.sv
module prg_range_match
  import prg_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int ADDR_W     = 24
) (
  input  prange_t [NUM_RANGES-1:0] ranges,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     is_write,
  output logic [NUM_RANGES-1:0]    hit_vec
);

  logic [31:0] addr_x;
  assign addr_x = 32'(addr);

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    logic covered;
    logic armed;
    assign covered    = range_covers(ranges[i], addr_x);
    assign armed      = is_write ? ranges[i].wp : ranges[i].rp;
    assign hit_vec[i] = covered && armed;
  end

endmodule

// File: rtl/flash_prot_guard.sv
module flash_prot_guard
  import prg_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_deny
);

  prange_t [NUM_RANGES-1:0] ranges;
  logic                     locked;
  logic [NUM_RANGES-1:0]    hit_vec;
  logic                     any_hit;

  prg_reg_bank #(.NUM_RANGES(NUM_RANGES), .OFF_W(8)) u_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ranges(ranges),
    .locked(locked)
  );

  prg_range_match #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) u_match (
    .ranges(ranges), .addr(req_addr), .is_write(req_write), .hit_vec(hit_vec)
  );

  assign any_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_deny  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_deny  <= req_valid && any_hit;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_deny)); // R9
  AST_DENY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> $past(any_hit)); // R4

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_chk
    AST_UNARMED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ranges[i].wp && !ranges[i].rp) |-> !hit_vec[i]); // R6
    AST_INVERTED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (ranges[i].base > ranges[i].limit)) |-> !hit_vec[i]); // R7
    AST_KIND_GATES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit_vec[i]) |-> (req_write ? ranges[i].wp : ranges[i].rp)); // R5
  end

endmodule

// File: tb/flash_prot_guard_test.sv
module flash_prot_guard_test;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          rsp_valid;
  logic          rsp_deny;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int mb[6];
  int ml[6];
  bit mr[6];
  bit mw[6];

  always #10 clk = ~clk;

  flash_prot_guard #(.NUM_RANGES(6), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_deny(rsp_deny)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int b, input int l, input bit r, input bit w);
    return (32'(w) << 31) | (32'(l & 16'h3fff) << 16) | (32'(r) << 15) | 32'(b & 16'h3fff);
  endfunction

  task automatic prog(input int k, input int b, input int l, input bit r, input bit w);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(4 * k); bus_wdata = mk(b, l, r, w);
    @(negedge clk);
    bus_we = 1'b0;
    mb[k] = b; ml[k] = l; mr[k] = r; mw[k] = w;
  endtask

  task automatic raw_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  function automatic bit model_deny(input longint a, input bit wr);
    bit d = 1'b0;
    for (int i = 0; i < 6; i++) begin
      longint lo = longint'(mb[i]) * 4096;
      longint hi = longint'(ml[i]) * 4096 + 4095;
      if ((mr[i] || mw[i]) && a >= lo && a <= hi && (wr ? mw[i] : mr[i])) d = 1'b1;
    end
    return d;
  endfunction

  task automatic req_chk(input longint a, input bit wr, input string tag);
    bit exp;
    exp = model_deny(a, wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9 valid after request", rsp_valid, 1);
    chk(rsp_deny === exp, tag, rsp_deny, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin mb[i] = 0; ml[i] = 0; mr[i] = 0; mw[i] = 0; end
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(rsp_valid === 1'b0, "R2 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 7; k++) rd_chk(8'(4 * k), 32'h0, "R2 register reset value");
    chk(rsp_valid === 1'b0, "R2 rsp_valid idle", rsp_valid, 0);

    // R1: unused bits read zero, fields land in place
    raw_wr(8'h14, 32'hffff_ffff);
    rd_chk(8'h14, 32'hbfff_bfff, "R1 reserved bits zero");
    prog(5, 16, 17, 1'b1, 1'b1);
    rd_chk(8'h14, mk(16, 17, 1, 1), "R1 field layout");

    // Mixed map
    prog(0, 2, 4, 1'b1, 1'b1);
    prog(1, 6, 6, 1'b0, 1'b1);   // R5 write only
    prog(2, 8, 9, 1'b1, 1'b0);   // R4 read only
    prog(3, 11, 12, 1'b0, 1'b0); // R6 unarmed
    prog(4, 14, 13, 1'b1, 1'b1); // R7 inverted
    for (int k = 0; k < 6; k++) rd_chk(8'(4 * k), mk(mb[k], ml[k], mr[k], mw[k]), "R1 readback");

    // R3 R4 R5 R6 R7: sweep every granule at first, middle, last byte
    for (int g = 0; g < 20; g++) begin
      for (int o = 0; o < 3; o++) begin
        longint a = longint'(g) * 4096 + (o == 0 ? 0 : (o == 1 ? 2048 : 4095));
        req_chk(a, 1'b0, "R4 R3 read sweep");
        req_chk(a, 1'b1, "R5 R3 write sweep");
      end
    end
    // idle after request
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_deny === 1'b0, "R9 idle drops valid", {rsp_valid, rsp_deny}, 0);

    // R8: lock
    rd_chk(8'h18, 32'h0, "R8 lock clear");
    raw_wr(8'h18, 32'h1);
    rd_chk(8'h18, 32'h1, "R8 lock set");
    raw_wr(8'h00, 32'h0);
    rd_chk(8'h00, mk(2, 4, 1, 1), "R8 range write ignored when locked");
    raw_wr(8'h0c, mk(11, 12, 1, 1));
    req_chk(longint'(11) * 4096, 1'b0, "R8 R6 locked range still unarmed");
    req_chk(longint'(3) * 4096 + 5, 1'b1, "R8 locked range still protects");
    raw_wr(8'h18, 32'h0);
    rd_chk(8'h18, 32'h1, "R8 lock not clearable");

    // R2: reset releases the lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin mb[i] = 0; ml[i] = 0; mr[i] = 0; mw[i] = 0; end
    rd_chk(8'h18, 32'h0, "R2 lock cleared by reset");
    rd_chk(8'h00, 32'h0, "R2 range cleared by reset");
    prog(0, 0, 0, 1'b1, 1'b0);
    rd_chk(8'h00, mk(0, 0, 1, 0), "R8 writable after reset");
    req_chk(4095, 1'b0, "R3 last byte of granule 0");
    req_chk(4096, 1'b0, "R3 first byte past limit");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule